// File: doc/BRIEF.md
# Reset Supervisor with Source Flags

This block drives the active-low reset of a host processor from three causes: a low-supply indication that arrives already synchronized from an external comparator, a manual press seen as an outside low level on the bidirectional reset pin, and a timeout pulse from a watchdog. One shared stretch counter holds reset low for a minimum number of ticks of a slow timebase strobe. For example, with one tick per millisecond and the default count, reset stays low for 100 ms. The count restarts whenever any cause is present. While the supply input stays low, reset stays low.

Two sticky flag bits record what caused each reset. One flag is shared by the supply and manual causes and the other belongs to the watchdog. Software reads and clears them through a small register port. The block also gates the start of serial bus transactions while reset is asserted, but a transaction that was already in flight when reset began is allowed to finish. When reset is released, a one-cycle pulse is emitted so the watchdog can restart.

Top module: `rst_supervisor`

## Requirements
- R1: After the block's own reset, `rst_n_o` is 1, `rst_release_o` is 0, `bus_lock_o` is 0 and `reg_rdata` is 0x00.
- R2: In every cycle after one in which `lowv_i` was 1, `rst_n_o` is 0, however many ticks occur.
- R3: Once every cause has gone, `rst_n_o` stays 0 until the STRETCH_TICKS-th tick strobe. It reads 1 in the cycle after that strobe is sampled, and not earlier.
- R4: When `rst_pin_i` is low and the block is not driving reset, the level is taken through SYNC_STAGES flops and then starts a stretch of STRETCH_TICKS ticks. The block's own driven low level never retriggers it, so reset stays released once the outside press has ended.
- R5: A one-cycle `wdt_timeout_i` pulse starts a stretch of STRETCH_TICKS ticks.
- R6: A supply or manual cause sets bit 6 of `reg_rdata`, and a watchdog cause sets bit 7. Both can read 1 together (0xC0).
- R7: A write (`reg_we`=1) clears each flag whose bit in `reg_wdata` is 0 and leaves each flag whose bit is 1. A hardware set in the same cycle wins over a clear. Bits 5..0 read 0.
- R8: `bus_lock_o` is 1 exactly when reset is asserted and no transaction is in flight. A `bus_start_i` is accepted only while `bus_lock_o` is 0, and it stays in flight until `bus_done_i`.
- R9: `rst_release_o` is a single-cycle pulse in the cycle in which `rst_n_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| tick_i | input | 1 | One-cycle timebase strobe |
| lowv_i | input | 1 | Synchronized low-supply indication, 1 = below trip point |
| rst_pin_i | input | 1 | Sensed level of the reset pin |
| wdt_timeout_i | input | 1 | One-cycle watchdog timeout pulse |
| reg_we | input | 1 | Flag register write strobe |
| reg_wdata | input | 8 | Flag register write data |
| reg_rdata | output | 8 | Flag register read data |
| bus_start_i | input | 1 | A serial transaction wants to start |
| bus_done_i | input | 1 | The in-flight serial transaction has finished |
| bus_lock_o | output | 1 | New serial transactions are blocked |
| rst_n_o | output | 1 | Active-low reset, 0 = drive pin low |
| rst_release_o | output | 1 | One-cycle pulse when reset is released |

## Verification
The hardest situation to reach is a manual press on a pin that the block itself pulls low. The bench models the pin as the AND of an outside switch and the block's own drive. It holds the switch long enough to cross the synchronizer, releases it, runs out the stretch, and then checks that reset stays released. The in-flight bus case is reached by starting a transaction before firing the watchdog, then checking the lockout before and after the done strobe.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
   localparam int REG_W   = 8;
   localparam int FLG_SUP = 6;   // supply or manual cause
   localparam int FLG_WDT = 7;   // watchdog cause

   typedef struct packed {
      logic wdt;
      logic sup;
   } cause_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_hi,
   input  logic pin_i,
   output logic pin_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rst_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   // While the block drives the pin, every stage is held high so that the
   // block's own low level never reaches the press detector.
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr[i] <= 1'b1;
            else if (hold_hi) sr[i] <= 1'b1;
            else if (i == 0)  sr[i] <= pin_i;
            else              sr[i] <= sr[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign pin_o = sr[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trig_i,
   output logic active_o,
   output logic release_o
);
   localparam int CW = $clog2(TICKS + 1);
   localparam logic [CW-1:0] LOAD = CW'(TICKS);

   generate
      if (TICKS < 2) begin : g_bad
         $error("rst_stretch: TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (trig_i)                cnt <= LOAD;
      else if (tick_i && cnt != '0)   cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= active_o;
   end

   assign active_o  = (cnt != '0);
   assign release_o = prev_q & ~active_o;

   // R3: release only happens on a tick with no cause present
   a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> ($past(tick_i) && !$past(trig_i)));
   // R9: release pulse is one cycle wide
   a_r9_release_single: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !release_o);
endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
   import rst_sup_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  cause_t           set_i,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] rdata_o
);
   cause_t flg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg <= '0;
      end else begin
         flg.sup <= set_i.sup | (flg.sup & ~(we_i & ~wdata_i[FLG_SUP]));
         flg.wdt <= set_i.wdt | (flg.wdt & ~(we_i & ~wdata_i[FLG_WDT]));
      end
   end

   always_comb begin
      rdata_o          = '0;
      rdata_o[FLG_SUP] = flg.sup;
      rdata_o[FLG_WDT] = flg.wdt;
   end

   // R6: a watchdog cause is recorded
   a_r6_wdt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i.wdt |=> rdata_o[FLG_WDT]);
   // R7: a flag stays set unless software clears it
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o[FLG_SUP] && !(we_i && !wdata_i[FLG_SUP])) |=> rdata_o[FLG_SUP]);
endmodule

// File: rtl/rst_bus_gate.sv
module rst_bus_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic start_i,
   input  logic done_i,
   output logic lock_o
);
   logic busy_q;

   assign lock_o = active_i & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_q <= 1'b0;
      else if (done_i)            busy_q <= 1'b0;
      else if (start_i && !lock_o) busy_q <= 1'b1;
   end

   // R8: a start presented while locked is not taken
   a_r8_locked_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && lock_o) |=> !busy_q);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
   import rst_sup_pkg::*;
#(
   parameter int STRETCH_TICKS = 100,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             lowv_i,
   input  logic             rst_pin_i,
   input  logic             wdt_timeout_i,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             bus_start_i,
   input  logic             bus_done_i,
   output logic             bus_lock_o,
   output logic             rst_n_o,
   output logic             rst_release_o
);
   logic   active;
   logic   pin_s;
   logic   press;
   logic   trig;
   cause_t cause;

   rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .hold_hi(active),
      .pin_i(rst_pin_i), .pin_o(pin_s));

   assign press     = ~pin_s & ~active;
   assign cause.sup = lowv_i | press;
   assign cause.wdt = wdt_timeout_i;
   assign trig      = cause.sup | cause.wdt;

   rst_stretch #(.TICKS(STRETCH_TICKS)) u_stretch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig),
      .active_o(active), .release_o(rst_release_o));

   rst_flag_reg u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(cause), .we_i(reg_we),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata));

   rst_bus_gate u_bus (
      .clk(clk), .rst_n(rst_n), .active_i(active), .start_i(bus_start_i),
      .done_i(bus_done_i), .lock_o(bus_lock_o));

   assign rst_n_o = ~active;

   // R2: low supply keeps reset asserted
   a_r2_lowv_holds: assert property (@(posedge clk) disable iff (!rst_n)
      lowv_i |=> !rst_n_o);
   // R5: watchdog timeout asserts reset
   a_r5_wdt_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_timeout_i |=> !rst_n_o);
   // R9: release pulse coincides with reset rising
   a_r9_release_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rst_release_o |-> (rst_n_o && $past(!rst_n_o)));
endmodule

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
   localparam int TK = 5;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       tick = 0, lowv = 0, ext_press = 0, wdt = 0;
   logic       we = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic       bstart = 0, bdone = 0, block;
   logic       rst_n_o, rel;
   logic       pin;

   int errors = 0, checks = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   assign pin = ~ext_press & rst_n_o;

   rst_supervisor #(.STRETCH_TICKS(TK), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .lowv_i(lowv), .rst_pin_i(pin),
      .wdt_timeout_i(wdt), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
      .bus_start_i(bstart), .bus_done_i(bdone), .bus_lock_o(block),
      .rst_n_o(rst_n_o), .rst_release_o(rel));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic one_tick();
      tick = 1; cyc(1); tick = 0;
   endtask

   task automatic clear_flags();
      we = 1; wdata = 8'h00; cyc(1); we = 0;
   endtask

   // Runs out a stretch: low before the last tick, high with release pulse after it
   task automatic run_out(input string req);
      for (int t = 1; t < TK; t++) begin
         one_tick(); cyc(1);
         chk(req, rst_n_o, 0);
      end
      one_tick();
      chk(req, rst_n_o, 1);
      chk("R9", rel, 1);
      cyc(1);
      chk("R9", rel, 0);
   endtask

   // source: 0 = supply, 1 = manual, 2 = watchdog; expected flag byte
   localparam int NV = 3;
   localparam logic [1:0] V_SRC [NV] = '{2'd0, 2'd1, 2'd2};
   localparam logic [7:0] V_FLG [NV] = '{8'h40, 8'h40, 8'h80};

   initial begin
      cyc(2);
      // R1 reset state
      chk("R1", rst_n_o, 1); chk("R1", rel, 0); chk("R1", block, 0); chk("R1", rdata, 0);
      rst_n = 1; cyc(2);
      chk("R1", rst_n_o, 1); chk("R1", rdata, 0);

      for (int v = 0; v < NV; v++) begin
         clear_flags();
         case (V_SRC[v])
            2'd0: begin
               lowv = 1; cyc(1);
               chk("R2", rst_n_o, 0);
               lowv = 0;
               run_out("R3");
            end
            2'd1: begin
               ext_press = 1; cyc(4); ext_press = 0;
               chk("R4", rst_n_o, 0);
               run_out("R4");
               cyc(6);
               chk("R4", rst_n_o, 1);   // own drive did not retrigger
            end
            default: begin
               wdt = 1; cyc(1); wdt = 0;
               chk("R5", rst_n_o, 0);
               run_out("R5");
            end
         endcase
         chk("R6", rdata, V_FLG[v]);
      end

      // R2: long supply dip with many ticks
      lowv = 1; cyc(1);
      for (int i = 0; i < 3 * TK; i++) begin
         one_tick(); chk("R2", rst_n_o, 0);
      end
      lowv = 0;
      run_out("R3");

      // R6 both flags, R7 selective clear
      wdt = 1; cyc(1); wdt = 0; run_out("R5");
      chk("R6", rdata, 8'hC0);
      we = 1; wdata = 8'h80; cyc(1); we = 0;
      chk("R7", rdata, 8'h80);
      we = 1; wdata = 8'h3F; cyc(1); we = 0;
      chk("R7", rdata, 8'h00);
      // R7 hardware set wins over clear
      wdt = 1; we = 1; wdata = 8'h00; cyc(1); wdt = 0; we = 0;
      chk("R7", rdata, 8'h80);
      chk("R8", block, 1);
      // R8 start while locked is dropped
      bstart = 1; cyc(1); bstart = 0;
      chk("R8", block, 1);
      run_out("R5");
      chk("R8", block, 0);

      // R8 in-flight transaction survives reset
      bstart = 1; cyc(1); bstart = 0;
      wdt = 1; cyc(1); wdt = 0;
      chk("R8", rst_n_o, 0);
      chk("R8", block, 0);
      bdone = 1; cyc(1); bdone = 0;
      chk("R8", block, 1);
      run_out("R5");
      chk("R8", block, 0);

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cyc(20000);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule